// File: doc/BRIEF.md
# Looping Record Player with Period-Locked Capture Gate

This block plays a sample record, held in on-chip RAM, out to a DAC data stream at one sample per output-rate tick. The host loads the record through a plain address/data/write port while playback is idle. It then chooses a record length and either single-pass or endless repeat, and issues a start. In repeat mode the last sample of one pass is followed on the very next tick by sample zero of the next pass, so a periodic stimulus has no gap.

Alongside the samples the block produces a one-cycle record-start strobe and a capture-window level for the ADC path. Both are derived from the playback read address. The window can only open on a record-start boundary and closes on a later one, after a programmed whole number of record periods. A capture gated by it therefore always holds an integer number of stimulus periods and needs no windowing before spectral analysis. The sample store depth is a parameter; a 32768-entry store of 16-bit samples suits a 24 Msps stimulus rate.

Top module: `arb_loop_gen`

## Requirements
- R1: A write with `wr_en` high while `busy` is low stores `wr_data` at `wr_addr`, and that value is output when playback reads that address.
- R2: An accepted start begins at address 0. Each cycle in which `tick` is high while playing (and `stop` is low) loads the sample at the current address into `dac_data`, visible the following cycle, and advances the address. In repeat mode the address returns to 0 after address `rec_len`-1 with no idle tick.
- R3: `start` is accepted only when `busy` is low, `stop` is low, and 1 <= `rec_len` <= DEPTH. Otherwise it has no effect and `busy` stays as it was.
- R4: In single-pass mode (`repeat_en` low at start), after the tick that reads address `rec_len`-1 the next cycle shows `busy` low and `done` high. At the next tick after that, `dac_data` becomes 0 if `zero_hold` was high at start; otherwise it keeps the last sample. `done` clears on the next accepted start.
- R5: `rec_start` is high for exactly the one cycle after a tick that reads address 0, and at no other time.
- R6: A write while `busy` is high does not change the store. It sets `wr_err`, which stays high until the next accepted start.
- R7: `cap_arm` is accepted only while the window is closed, no arm is pending and `cap_reps` is nonzero. After acceptance, `cap_window` rises in the same cycle as the next `rec_start`, stays high for exactly `cap_reps` record periods, and falls in the cycle of the `rec_start` that ends the last of them.
- R8: In single-pass mode an open window falls at the tick after the final sample, together with the zero/hold update.
- R9: `stop` has priority over `start` and over a coincident `tick`. That tick reads no sample and gives no `rec_start`. Next cycle `busy` and `cap_window` are low and any pending arm is discarded. `dac_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Output-rate sample enable |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Host write address, AW = log2(DEPTH) |
| wr_data | input | DW | Host write sample |
| rec_len | input | AW+1 | Record length, sampled at start |
| repeat_en | input | 1 | 1 = endless repeat, 0 = single pass; sampled at start |
| zero_hold | input | 1 | Single pass ends on zero instead of last sample; sampled at start |
| start | input | 1 | Start playback pulse |
| stop | input | 1 | Stop playback pulse |
| cap_arm | input | 1 | Request a capture window |
| cap_reps | input | RW | Number of record periods the window covers |
| dac_data | output | DW | Sample to DAC |
| rec_start | output | 1 | One-cycle strobe when record address 0 is output |
| cap_window | output | 1 | Capture gate for the ADC path |
| busy | output | 1 | Playback running |
| done | output | 1 | Single pass completed |
| wr_err | output | 1 | A write was attempted during playback |

## Verification
The bench builds the block with DEPTH = 64, DW = 16 and RW = 4. With these values a full-depth record of 64 samples fits in a few hundred cycles, so the wrap at the last store address and the out-of-range length 65 can both be exercised. The 4-bit repeat count lets a window of several whole periods open and close many times in one run. Ticks run both on every cycle and at one in three cycles. This covers back-to-back strobes with a one-sample record, a stop that coincides with a tick, and the zero/hold update at a tick after single-pass completion.

// File: rtl/arb_loop_pkg.sv
package arb_loop_pkg;

  typedef struct packed {
    logic rd;     // a sample is read this cycle
    logic first;  // the read is of address 0
    logic wrap;   // the read is of the last record address
    logic tail;   // the tick after a single pass finished
  } play_evt_t;

  function automatic bit len_valid(input int unsigned len, input int unsigned depth);
    return (len != 0) && (len <= depth);
  endfunction

  function automatic bit is_last(input int unsigned addr, input int unsigned len);
    return (addr + 1) == len;
  endfunction

endpackage

// File: rtl/arb_rec_ram.sv
module arb_rec_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  input  logic          clr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata <= '0;
    else if (re)  rdata <= mem[raddr];
    else if (clr) rdata <= '0;
  end
endmodule

// File: rtl/arb_play_seq.sv
module arb_play_seq
  import arb_loop_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          stop,
  input  logic [LW-1:0] rec_len,
  input  logic          repeat_en,
  input  logic          zero_hold,
  input  logic          wr_en,
  output logic [AW-1:0] rd_addr,
  output logic [LW-1:0] len_q,
  output play_evt_t     evt,
  output logic          zclr,
  output logic          wr_ok,
  output logic          busy,
  output logic          done,
  output logic          wr_err
);
  logic          run_q, rep_q, zh_q, tail_q, done_q, err_q;
  logic [AW-1:0] addr_q;
  logic          start_ok, rd, last, tail_tick;

  assign start_ok  = start && !stop && !run_q && len_valid(32'(rec_len), DEPTH);
  assign rd        = tick && run_q && !stop;
  assign last      = is_last(32'(addr_q), 32'(len_q));
  assign tail_tick = tick && tail_q && !stop;

  assign evt.rd    = rd;
  assign evt.first = rd && (addr_q == '0);
  assign evt.wrap  = rd && last;
  assign evt.tail  = tail_tick;
  assign zclr      = tail_tick && zh_q;
  assign wr_ok     = wr_en && !run_q;

  assign rd_addr = addr_q;
  assign busy    = run_q;
  assign done    = done_q;
  assign wr_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      rep_q  <= 1'b0;
      zh_q   <= 1'b0;
      tail_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
    end else begin
      if (stop) begin
        run_q  <= 1'b0;
        tail_q <= 1'b0;
      end else if (start_ok) begin
        run_q  <= 1'b1;
        addr_q <= '0;
        len_q  <= rec_len;
        rep_q  <= repeat_en;
        zh_q   <= zero_hold;
        done_q <= 1'b0;
        tail_q <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        if (rd) begin
          if (last) begin
            addr_q <= '0;
            if (!rep_q) begin
              run_q  <= 1'b0;
              done_q <= 1'b1;
              tail_q <= 1'b1;
            end
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        if (tail_tick) tail_q <= 1'b0;
      end
      if (wr_en && run_q) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/arb_cap_gate.sv
module arb_cap_gate #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [RW-1:0] reps,
  input  logic          first,
  input  logic          clear_all,
  input  logic          close,
  output logic          win
);
  logic          win_q, armed_q;
  logic [RW-1:0] reps_q, left_q;
  logic          arm_ok;

  assign arm_ok = arm && !win_q && !armed_q && (reps != '0);
  assign win    = win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= 1'b0;
      armed_q <= 1'b0;
      reps_q  <= '0;
      left_q  <= '0;
    end else if (clear_all) begin
      win_q   <= 1'b0;
      armed_q <= 1'b0;
      left_q  <= '0;
    end else begin
      if (arm_ok) begin
        armed_q <= 1'b1;
        reps_q  <= reps;
      end
      if (first) begin
        if (armed_q) begin
          win_q   <= 1'b1;
          left_q  <= reps_q;
          armed_q <= 1'b0;
        end else if (win_q) begin
          if (left_q == RW'(1)) begin
            win_q  <= 1'b0;
            left_q <= '0;
          end else begin
            left_q <= left_q - 1'b1;
          end
        end
      end
      if (close) begin
        win_q  <= 1'b0;
        left_q <= '0;
      end
    end
  end
endmodule

// File: rtl/arb_loop_gen.sv
module arb_loop_gen
  import arb_loop_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 2048,
  parameter int RW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [LW-1:0] rec_len,
  input  logic          repeat_en,
  input  logic          zero_hold,
  input  logic          start,
  input  logic          stop,
  input  logic          cap_arm,
  input  logic [RW-1:0] cap_reps,
  output logic [DW-1:0] dac_data,
  output logic          rec_start,
  output logic          cap_window,
  output logic          busy,
  output logic          done,
  output logic          wr_err
);
  logic [AW-1:0] rd_addr;
  logic [LW-1:0] len_q;
  play_evt_t     evt;
  logic          zclr, wr_ok, rs_q;

  arb_play_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
    .rec_len(rec_len), .repeat_en(repeat_en), .zero_hold(zero_hold),
    .wr_en(wr_en), .rd_addr(rd_addr), .len_q(len_q), .evt(evt),
    .zclr(zclr), .wr_ok(wr_ok), .busy(busy), .done(done), .wr_err(wr_err)
  );

  arb_rec_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(wr_ok), .waddr(wr_addr), .wdata(wr_data),
    .re(evt.rd), .raddr(rd_addr), .clr(zclr), .rdata(dac_data)
  );

  arb_cap_gate #(.RW(RW)) u_cap (
    .clk(clk), .rst_n(rst_n), .arm(cap_arm), .reps(cap_reps),
    .first(evt.first), .clear_all(stop), .close(evt.tail), .win(cap_window)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 1'b0;
    else        rs_q <= evt.first;
  end
  assign rec_start = rs_q;
endmodule

// File: rtl/arb_loop_gen_chk.sv
module arb_loop_gen_chk #(
  parameter int AW = 11,
  parameter int LW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic          stop,
  input logic          busy,
  input logic          done,
  input logic          wr_err,
  input logic          rec_start,
  input logic          cap_window,
  input logic [AW-1:0] rd_addr,
  input logic [LW-1:0] len_q
);
  p_addr_in_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, rd_addr} < len_q));

  p_strobe_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_start |-> $past(tick && busy && !stop));

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_err_on_busy_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> wr_err);

  p_win_opens_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_window) |-> rec_start);

  p_win_closes_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_window) |-> (rec_start || !busy));

  p_stop_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy && !rec_start && !cap_window));
endmodule

bind arb_loop_gen arb_loop_gen_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .stop(stop),
  .busy(busy), .done(done), .wr_err(wr_err), .rec_start(rec_start),
  .cap_window(cap_window), .rd_addr(rd_addr), .len_q(len_q)
);

// File: tb/arb_loop_gen_tb.sv
module arb_loop_gen_tb;
  localparam int DW = 16, DEPTH = 64, RW = 4;
  localparam int AW = $clog2(DEPTH), LW = AW + 1;

  logic clk = 0, rst_n = 0, tick = 0;
  logic wr_en = 0, repeat_en = 0, zero_hold = 0, start = 0, stop = 0, cap_arm = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [LW-1:0] rec_len = '0;
  logic [RW-1:0] cap_reps = '0;
  logic [DW-1:0] dac_data;
  logic rec_start, cap_window, busy, done, wr_err;

  arb_loop_gen #(.DW(DW), .DEPTH(DEPTH), .RW(RW)) u_dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, tick_per = 1, phase = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int pat(input int i);
    return (i * 1234 + 77) & 16'hFFFF;
  endfunction

  // reference model state
  int m_mem [DEPTH];
  int m_addr, m_len, m_dac, m_left, m_reps;
  bit m_run, m_rep, m_zh, m_tail, m_done, m_err, m_rs, m_win, m_armed;
  bit o_run, o_tail, o_win, o_armed, rd, ttk, first;
  int o_addr;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_rep = 0; m_zh = 0; m_tail = 0; m_done = 0; m_err = 0;
      m_rs = 0; m_win = 0; m_armed = 0; m_addr = 0; m_len = 0; m_dac = 0;
      m_left = 0; m_reps = 0;
    end else begin
      o_run = m_run; o_tail = m_tail; o_win = m_win; o_armed = m_armed; o_addr = m_addr;
      rd    = tick && o_run && !stop;
      ttk   = tick && o_tail && !stop;
      first = rd && (o_addr == 0);
      if (wr_en) begin
        if (o_run) m_err = 1;
        else m_mem[wr_addr] = int'(wr_data);
      end
      m_rs = first;
      if (rd) m_dac = m_mem[o_addr];
      else if (ttk && m_zh) m_dac = 0;
      if (stop) begin
        m_win = 0; m_armed = 0; m_left = 0;
      end else begin
        if (cap_arm && !o_win && !o_armed && cap_reps != 0) begin
          m_armed = 1; m_reps = int'(cap_reps);
        end
        if (first && o_armed) begin
          m_win = 1; m_left = m_reps; m_armed = 0;
        end else if (first && o_win) begin
          m_left--;
          if (m_left == 0) m_win = 0;
        end
        if (ttk) m_win = 0;
      end
      if (stop) begin
        m_run = 0; m_tail = 0;
      end else if (start && !o_run && rec_len >= 1 && rec_len <= DEPTH) begin
        m_run = 1; m_addr = 0; m_len = int'(rec_len); m_rep = repeat_en;
        m_zh = zero_hold; m_done = 0; m_tail = 0; m_err = 0;
      end else begin
        if (rd) begin
          if (o_addr == m_len - 1) begin
            m_addr = 0;
            if (!m_rep) begin m_run = 0; m_done = 1; m_tail = 1; end
          end else m_addr++;
        end
        if (ttk) m_tail = 0;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(dac_data) == m_dac, "R2 dac_data", int'(dac_data), m_dac);
      chk(rec_start == m_rs, "R5 rec_start", int'(rec_start), int'(m_rs));
      chk(cap_window == m_win, "R7 cap_window", int'(cap_window), int'(m_win));
      chk(busy == m_run, "R3 busy", int'(busy), int'(m_run));
      chk(done == m_done, "R4 done", int'(done), int'(m_done));
      chk(wr_err == m_err, "R6 wr_err", int'(wr_err), int'(m_err));
    end
  end

  // tick generator
  always @(negedge clk) begin
    phase = (phase + 1) % tick_per;
    tick = (phase == 0);
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_start(input int len, input bit rep, input bit zh);
    @(negedge clk); start = 1; rec_len = LW'(len); repeat_en = rep; zero_hold = zh;
    @(negedge clk); start = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic do_arm(input int reps);
    @(negedge clk); cap_arm = 1; cap_reps = RW'(reps);
    @(negedge clk); cap_arm = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
  endtask

  initial begin
    idle(4);
    chk(dac_data == 0 && !busy && !done && !wr_err && !rec_start && !cap_window,
        "R2 reset state", int'(dac_data), 0);
    @(negedge clk); rst_n = 1;

    // R1: load the whole store while idle
    for (int i = 0; i < DEPTH; i++) do_write(i, pat(i));
    chk(!wr_err, "R1 idle writes raise no error", int'(wr_err), 0);

    // R3: out-of-range lengths are ignored
    do_start(0, 1, 0); idle(2);
    chk(!busy, "R3 length 0 ignored", int'(busy), 0);
    do_start(DEPTH + 1, 1, 0); idle(2);
    chk(!busy, "R3 length above depth ignored", int'(busy), 0);

    // R2/R7: repeat mode, length 5, window of 2 periods armed before start
    tick_per = 1;
    do_arm(2);
    do_start(5, 1, 0);
    idle(12);
    do_write(2, 16'hFFFF);            // R6: write while playing
    chk(wr_err, "R6 busy write flags error", int'(wr_err), 1);
    do_start(9, 1, 0);                // R3: start while running ignored
    idle(20);
    do_arm(3); idle(40);
    do_stop(); idle(1);               // R8/R9: stop (coincides with a tick)
    chk(!busy && !cap_window, "R8 stop idles and closes window", int'(busy), 0);
    chk(int'(dac_data) != 0, "R9 stop keeps last sample", int'(dac_data), 1);

    // R5: one-sample record gives back-to-back strobes
    do_start(1, 1, 0); idle(6);
    chk(rec_start, "R5 length 1 strobes every tick", int'(rec_start), 1);
    do_stop();

    // R4/R8: single pass with zero hold, ticks every 3 cycles, window armed
    tick_per = 3;
    do_arm(4);
    do_start(3, 0, 1);
    wait_done();
    chk(done && !busy, "R4 single pass completes", int'(done), 1);
    idle(8);
    chk(dac_data == 0, "R4 zero hold after pass", int'(dac_data), 0);
    chk(!cap_window, "R8 window closed after single pass", int'(cap_window), 0);

    // R4: single-sample pulse holding the last sample
    do_start(1, 0, 0);
    wait_done(); idle(8);
    chk(int'(dac_data) == pat(0), "R4 hold last sample", int'(dac_data), pat(0));

    // R7: zero repeat count ignored, then full-depth wrap with window
    tick_per = 1;
    do_arm(0);
    do_start(DEPTH, 1, 0);
    idle(DEPTH + 4);
    chk(!cap_window, "R7 zero count arm ignored", int'(cap_window), 0);
    do_arm(2);
    idle(3 * DEPTH + 10);
    do_stop(); idle(2);

    // R1/R6: address 2 still holds the original sample after the refused write
    tick_per = 1;
    do_start(3, 0, 0);
    wait_done(); idle(2);
    chk(int'(dac_data) == pat(2), "R6 refused write left store intact", int'(dac_data), pat(2));
    chk(!wr_err, "R6 start clears error", int'(wr_err), 0);

    idle(5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule